// File: doc/BRIEF.md
# Parallel Bus Master

This block sits between an on-chip host and an external parallel device. It converts one host read or write request into a short sequence of pin-level bus cycles. Each bus cycle spans two cycles of the internal clock: a low half and a high half of the optional bus clock. The block can drive an address bus of selectable width, a data bus with an output-enable, optional read and write strobes, and an optional bus clock. An optional ready input can hold off the end of any bus cycle.

Static configuration inputs control the behaviour. The bus clock can be off, free-running or gated. The strobes can be used or left undriven. The ready input can be honoured or ignored. A write can take one bus cycle, or be split into an address cycle followed by a data cycle. A read always takes two bus cycles: an address cycle, then a data cycle whose end samples the data bus.

The host raises a request with direction, address and write data, and holds it until the block returns a one-clock acknowledge. Read data is valid alongside that acknowledge. Only one transaction is in flight at a time.

Top module: `pbus_master`

## Requirements
- R1: After reset the block is idle: `bus_rd`, `bus_wr`, `bus_doe` and `ack` are low, and `bus_addr` and `bus_dout` are all zero.
- R2: With `cfg_clk_en` low, `bus_clk` is held low at all times, including during transactions.
- R3: With the clock enabled and `cfg_clk_gated` low, `bus_clk` changes level on every internal clock cycle: low in the first half of each bus cycle and high in the second.
- R4: With the clock enabled and `cfg_clk_gated` high, `bus_clk` stays high while idle. During a transaction it is low for the first half of each bus cycle, so it rises at the end of every bus cycle (read: 2 low halves, single-cycle write: 1, split write: 2).
- R5: With `cfg_strobe_en` low, `bus_rd` and `bus_wr` never assert, and reads and writes still complete.
- R6: A read drives `bus_rd` together with the address for one bus cycle, then runs a data bus cycle with `bus_rd` and `bus_doe` low. `bus_din` is sampled at the end of that data cycle and returned on `rdata`.
- R7: When `cfg_wr_split` is low, a write drives `bus_wr`, the address, `bus_dout` and `bus_doe` together for one bus cycle.
- R8: When `cfg_wr_split` is high, a write first drives `bus_wr` with the address and `bus_doe` low for one bus cycle. It then drives `bus_doe` and `bus_dout` for one bus cycle with `bus_wr` low, so `bus_wr` and `bus_doe` are never high together.
- R9: When `cfg_rdy_en` is high and the clock is enabled and free-running, `bus_rdy` low at the end of a bus cycle makes the same phase repeat for another whole bus cycle, whatever phase it is.
- R10: When `cfg_rdy_en` is low, or the bus clock is gated or disabled, `bus_rdy` has no effect on timing.
- R11: `cfg_addr_mode` selects the number of driven address bits: 0 gives none, 1 gives 8, 2 gives 12, 3 gives 20. Bits above the selected width are driven to zero.
- R12: `cfg_data_mode` selects the data width: 0 gives 8 bits, 1 gives 16, 2 or 3 give 32. Unused upper bits of `bus_dout` are driven to zero, and the same bits of `rdata` read as zero.
- R13: Each accepted request gets exactly one `ack`, one internal clock wide, in the clock cycle right after the edge that ends the final bus cycle. A new request is taken only when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_en | input | 1 | Drive a bus clock |
| cfg_clk_gated | input | 1 | Gated rather than free-running bus clock |
| cfg_strobe_en | input | 1 | Drive read and write strobes |
| cfg_rdy_en | input | 1 | Honour the ready input |
| cfg_wr_split | input | 1 | Split writes into address and data cycles |
| cfg_addr_mode | input | 2 | Address width select |
| cfg_data_mode | input | 2 | Data width select |
| req | input | 1 | Host request, held until ack |
| req_we | input | 1 | Request is a write |
| req_addr | input | 20 | Request address |
| req_wdata | input | 32 | Request write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read data, valid with ack |
| bus_clk | output | 1 | Bus clock |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 20 | Address bus |
| bus_dout | output | 32 | Data bus, outbound value |
| bus_doe | output | 1 | Data bus output-enable |
| bus_din | input | 32 | Data bus, inbound value |
| bus_rdy | input | 1 | Ready from the external device |

## Verification
Some properties can be checked on every cycle, and the assertions cover these. The bus clock must stay low when disabled, toggle when free-running, and stay high when gated and idle. The strobes must stay silent when disabled. Output-enable must never coincide with the read strobe or, in split mode, with the write strobe. Address and data bits above the selected widths must stay zero. A ready stall must freeze the sequencer and hold off the acknowledge, and the acknowledge must last one clock. Other behaviour can only be shown by the bench scenarios: the exact number of clocks each strobe and output-enable stays high for each transaction kind and stall depth, the number of gated clock pulses per transaction, the captured read data under each data width, and completion when ready is held low but is not honoured.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int MODE_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RADDR = 3'd1,
    ST_RDATA = 3'd2,
    ST_WADDR = 3'd3,
    ST_WDATA = 3'd4,
    ST_WONE  = 3'd5
  } bus_state_t;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } host_req_t;

  // number of address bits driven for a width selection
  function automatic int addr_bits(input logic [MODE_W-1:0] mode);
    case (mode)
      2'd0:    return 0;
      2'd1:    return 8;
      2'd2:    return 12;
      default: return ADDR_W;
    endcase
  endfunction

  function automatic int data_bits(input logic [MODE_W-1:0] mode);
    case (mode)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return DATA_W;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] addr_keep(input logic [MODE_W-1:0] mode,
                                                  input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    int n;
    n = addr_bits(mode);
    m = '0;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i < n);
    return a & m;
  endfunction

  function automatic logic [DATA_W-1:0] data_keep(input logic [MODE_W-1:0] mode,
                                                  input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] m;
    int n;
    n = data_bits(mode);
    m = '0;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < n);
    return d & m;
  endfunction

  // first phase of a new transaction
  function automatic bus_state_t first_phase(input logic we, input logic split);
    if (!we)   return ST_RADDR;
    if (split) return ST_WADDR;
    return ST_WONE;
  endfunction

  // phases whose end finishes the transaction
  function automatic logic is_final(input bus_state_t s);
    return (s == ST_RDATA) || (s == ST_WDATA) || (s == ST_WONE);
  endfunction

endpackage

// File: rtl/pbus_phase.sv
// Half-cycle tracker: each bus cycle is two internal clocks.
module pbus_phase (
  input  logic clk,
  input  logic rst_n,
  output logic ph_hi,
  output logic tick
);
  logic ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  assign ph_hi = ph_q;
  // the edge that closes the high half ends a bus cycle
  assign tick  = ph_q;
endmodule

// File: rtl/pbus_fsm.sv
module pbus_fsm
  import pbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ready_ok,
  input  logic       req,
  input  logic       req_we,
  input  logic       cfg_wr_split,
  output bus_state_t state,
  output logic       busy,
  output logic       accept,
  output logic       advance,
  output logic       done
);
  bus_state_t st_q, st_d;

  assign busy    = (st_q != ST_IDLE);
  assign accept  = tick && !busy && req;
  assign advance = tick && busy && ready_ok;
  assign done    = advance && is_final(st_q);

  always_comb begin
    st_d = st_q;
    if (accept) begin
      st_d = first_phase(req_we, cfg_wr_split);
    end else if (advance) begin
      case (st_q)
        ST_RADDR: st_d = ST_RDATA;
        ST_WADDR: st_d = ST_WDATA;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/pbus_pins.sv
module pbus_pins
  import pbus_pkg::*;
(
  input  logic               cfg_clk_en,
  input  logic               cfg_clk_gated,
  input  logic               cfg_strobe_en,
  input  logic [MODE_W-1:0]  cfg_addr_mode,
  input  logic [MODE_W-1:0]  cfg_data_mode,
  input  bus_state_t         state,
  input  logic               ph_hi,
  input  host_req_t          cur,
  output logic               bus_clk,
  output logic               bus_rd,
  output logic               bus_wr,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_dout,
  output logic               bus_doe
);
  logic busy, rd_phase, wr_phase, data_phase;

  assign busy       = (state != ST_IDLE);
  assign rd_phase   = (state == ST_RADDR);
  assign wr_phase   = (state == ST_WADDR) || (state == ST_WONE);
  assign data_phase = (state == ST_WDATA) || (state == ST_WONE);

  always_comb begin
    if (!cfg_clk_en)        bus_clk = 1'b0;
    else if (!cfg_clk_gated) bus_clk = ph_hi;
    else                    bus_clk = busy ? ph_hi : 1'b1;
  end

  assign bus_rd   = cfg_strobe_en && rd_phase;
  assign bus_wr   = cfg_strobe_en && wr_phase;
  assign bus_doe  = data_phase;
  assign bus_addr = busy ? addr_keep(cfg_addr_mode, cur.addr) : '0;
  assign bus_dout = data_phase ? data_keep(cfg_data_mode, cur.wdata) : '0;
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clk_en,
  input  logic              cfg_clk_gated,
  input  logic              cfg_strobe_en,
  input  logic              cfg_rdy_en,
  input  logic              cfg_wr_split,
  input  logic [1:0]        cfg_addr_mode,
  input  logic [1:0]        cfg_data_mode,
  input  logic              req,
  input  logic              req_we,
  input  logic [19:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              ack,
  output logic [31:0]       rdata,
  output logic              bus_clk,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [19:0]       bus_addr,
  output logic [31:0]       bus_dout,
  output logic              bus_doe,
  input  logic [31:0]       bus_din,
  input  logic              bus_rdy
);
  logic       ph_hi, tick, busy, accept, advance, done;
  logic       rdy_honoured, ready_ok;
  bus_state_t state;
  host_req_t  cur_q;
  logic       ack_q;
  logic [DATA_W-1:0] rdata_q;

  // ready only counts with a running, free bus clock
  assign rdy_honoured = cfg_rdy_en && cfg_clk_en && !cfg_clk_gated;
  assign ready_ok     = !rdy_honoured || bus_rdy;

  pbus_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .ph_hi (ph_hi),
    .tick  (tick)
  );

  pbus_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .ready_ok     (ready_ok),
    .req          (req),
    .req_we       (req_we),
    .cfg_wr_split (cfg_wr_split),
    .state        (state),
    .busy         (busy),
    .accept       (accept),
    .advance      (advance),
    .done         (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        cur_q.we    <= req_we;
        cur_q.addr  <= req_addr;
        cur_q.wdata <= req_wdata;
      end
      ack_q <= done;
      if (done && !cur_q.we) rdata_q <= data_keep(cfg_data_mode, bus_din);
    end
  end

  pbus_pins u_pins (
    .cfg_clk_en    (cfg_clk_en),
    .cfg_clk_gated (cfg_clk_gated),
    .cfg_strobe_en (cfg_strobe_en),
    .cfg_addr_mode (cfg_addr_mode),
    .cfg_data_mode (cfg_data_mode),
    .state         (state),
    .ph_hi         (ph_hi),
    .cur           (cur_q),
    .bus_clk       (bus_clk),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_dout      (bus_dout),
    .bus_doe       (bus_doe)
  );

  assign ack   = ack_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/pbus_master_chk.sv
module pbus_master_chk
  import pbus_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_clk_en,
  input logic        cfg_clk_gated,
  input logic        cfg_strobe_en,
  input logic        cfg_rdy_en,
  input logic        cfg_wr_split,
  input logic [1:0]  cfg_addr_mode,
  input logic [1:0]  cfg_data_mode,
  input logic        ack,
  input logic        bus_clk,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [19:0] bus_addr,
  input logic [31:0] bus_dout,
  input logic        bus_doe,
  input logic        bus_rdy,
  input logic        tick,
  input logic        busy,
  input bus_state_t  state
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_clk_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clk_en |-> !bus_clk);

  p_free_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cfg_clk_en && !cfg_clk_gated && $past(cfg_clk_en && !cfg_clk_gated))
      |-> (bus_clk != $past(bus_clk)));

  p_gated_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_en && cfg_clk_gated && !busy) |-> bus_clk);

  p_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_strobe_en |-> (!bus_rd && !bus_wr));

  p_read_no_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !bus_rd);

  p_rd_into_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd) |-> (busy && !bus_doe));

  p_split_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_split |-> !(bus_wr && bus_doe));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && busy && cfg_rdy_en && cfg_clk_en && !cfg_clk_gated && !bus_rdy)
      |=> (!ack && $stable(state)));

  p_addr_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr_mode == 2'd0) |-> (bus_addr == 20'h0));

  p_addr_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr_mode == 2'd1) |-> (bus_addr[19:8] == 12'h0));

  p_data_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_data_mode == 2'd0) |-> (bus_dout[31:8] == 24'h0));

  p_ack_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

bind pbus_master pbus_master_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_clk_en    (cfg_clk_en),
  .cfg_clk_gated (cfg_clk_gated),
  .cfg_strobe_en (cfg_strobe_en),
  .cfg_rdy_en    (cfg_rdy_en),
  .cfg_wr_split  (cfg_wr_split),
  .cfg_addr_mode (cfg_addr_mode),
  .cfg_data_mode (cfg_data_mode),
  .ack           (ack),
  .bus_clk       (bus_clk),
  .bus_rd        (bus_rd),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_dout      (bus_dout),
  .bus_doe       (bus_doe),
  .bus_rdy       (bus_rdy),
  .tick          (tick),
  .busy          (busy),
  .state         (state)
);

// File: tb/tb_pbus_master.sv
module tb_pbus_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic cfg_clk_en = 1'b1, cfg_clk_gated = 1'b0, cfg_strobe_en = 1'b1;
  logic cfg_rdy_en = 1'b1, cfg_wr_split = 1'b0;
  logic [1:0] cfg_addr_mode = 2'd3, cfg_data_mode = 2'd2;
  logic req = 1'b0, req_we = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic ack;
  logic [31:0] rdata;
  logic bus_clk, bus_rd, bus_wr, bus_doe;
  logic [19:0] bus_addr;
  logic [31:0] bus_dout;
  logic [31:0] bus_din = '0;
  logic bus_rdy = 1'b1;

  pbus_master dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_clk_en(cfg_clk_en), .cfg_clk_gated(cfg_clk_gated),
    .cfg_strobe_en(cfg_strobe_en), .cfg_rdy_en(cfg_rdy_en),
    .cfg_wr_split(cfg_wr_split), .cfg_addr_mode(cfg_addr_mode),
    .cfg_data_mode(cfg_data_mode),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .rdata(rdata),
    .bus_clk(bus_clk), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_rdy(bus_rdy)
  );

  typedef struct {
    string       tag;
    logic        we;
    logic [19:0] addr;
    logic [31:0] data;
    int          n_rd, n_wr, n_doe, n_both, n_low;
    bit          chk_addr, chk_low;
  } exp_t;

  exp_t expq[$];
  int n_checks = 0, n_errors = 0, n_acks = 0, n_txn = 0;
  int m_rd = 0, m_wr = 0, m_doe = 0, m_both = 0, m_low = 0;
  logic [19:0] m_addr = '0;
  logic [31:0] m_data = '0;
  logic prev_ack = 1'b0;
  int stall_left = 0;
  bit force_low = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] low_bits(input logic [31:0] v, input int n);
    if (n >= 32) return v;
    return v & ((32'h1 << n) - 32'h1);
  endfunction

  function automatic int a_width(input logic [1:0] m);
    int w [4] = '{0, 8, 12, 20};
    return w[m];
  endfunction

  function automatic int d_width(input logic [1:0] m);
    int w [4] = '{8, 16, 32, 32};
    return w[m];
  endfunction

  // monitor and device model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (ack) begin
        n_acks++;
        if (prev_ack) chk("R13", "ack width", 32'd2, 32'd1);
        if (expq.size() == 0) begin
          chk("R13", "unexpected ack", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(e.tag, "rd clocks", m_rd, e.n_rd);
          chk(e.tag, "wr clocks", m_wr, e.n_wr);
          chk(e.tag, "oe clocks", m_doe, e.n_doe);
          chk(e.tag, "wr with oe clocks", m_both, e.n_both);
          if (e.chk_low) chk(e.tag, "gated low halves", m_low, e.n_low);
          if (e.chk_addr) chk(e.tag, "address", {12'h0, m_addr}, {12'h0, e.addr});
          if (e.we) chk(e.tag, "bus data", m_data, e.data);
          else      chk(e.tag, "read data", rdata, e.data);
        end
        m_rd = 0; m_wr = 0; m_doe = 0; m_both = 0; m_low = 0;
      end else if (req) begin
        if (bus_rd) m_rd++;
        if (bus_wr) m_wr++;
        if (bus_doe) m_doe++;
        if (bus_wr && bus_doe) m_both++;
        if (!bus_clk) m_low++;
        if (bus_rd || bus_wr || bus_doe) m_addr = bus_addr;
        if (bus_doe) m_data = bus_dout;
      end
      prev_ack = ack;
    end
    if (force_low) bus_rdy = 1'b0;
    else if (stall_left > 0 && bus_clk && (bus_rd || bus_wr || bus_doe)) begin
      bus_rdy = 1'b0;
      stall_left--;
    end else bus_rdy = 1'b1;
  end

  // driver: push expectation, run handshake
  task automatic txn(input string tag, input logic we, input logic [19:0] a,
                     input logic [31:0] wd, input logic [31:0] din_v, input int stall);
    exp_t e;
    int eff, cyc;
    eff = (cfg_rdy_en && cfg_clk_en && !cfg_clk_gated) ? stall : 0;
    e.tag = tag;
    e.we = we;
    e.addr = low_bits({12'h0, a}, a_width(cfg_addr_mode)) [19:0];
    e.data = we ? low_bits(wd, d_width(cfg_data_mode)) : low_bits(din_v, d_width(cfg_data_mode));
    e.n_rd = (cfg_strobe_en && !we) ? 2 * (1 + eff) : 0;
    e.n_wr = (cfg_strobe_en && we) ? 2 * (1 + eff) : 0;
    e.n_doe = !we ? 0 : (cfg_wr_split ? 2 : 2 * (1 + eff));
    e.n_both = (we && !cfg_wr_split && cfg_strobe_en) ? 2 * (1 + eff) : 0;
    cyc = (!we || cfg_wr_split) ? 2 : 1;
    e.n_low = cyc;
    e.chk_low = cfg_clk_en && cfg_clk_gated;
    e.chk_addr = cfg_strobe_en || we;
    expq.push_back(e);
    n_txn++;
    stall_left = stall;
    bus_din = din_v;
    req_we = we;
    req_addr = a;
    req_wdata = wd;
    req = 1'b1;
    do @(negedge clk); while (!ack);
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    logic prev;
    repeat (3) @(negedge clk);
    // R1: idle state after reset, checked while reset is held and after release
    chk("R1", "rd", bus_rd, 1'b0);
    chk("R1", "wr", bus_wr, 1'b0);
    chk("R1", "oe", bus_doe, 1'b0);
    chk("R1", "ack", ack, 1'b0);
    chk("R1", "addr", {12'h0, bus_addr}, 32'h0);
    chk("R1", "dout", bus_dout, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "oe after release", bus_doe, 1'b0);

    // R3: free-running clock toggles every internal clock
    cnt = 0; prev = bus_clk;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (bus_clk != prev) cnt++;
      prev = bus_clk;
    end
    chk("R3", "toggles in 8 clocks", cnt, 8);

    // R6, R7: basic read and single-cycle write at full width
    txn("R6", 1'b0, 20'hA5C3E, 32'h0, 32'hDEADBEEF, 0);
    txn("R7", 1'b1, 20'h1234F, 32'hCAFEF00D, 32'h0, 0);
    // R13: back-to-back requests, each acknowledged once
    txn("R13", 1'b0, 20'h00001, 32'h0, 32'h11223344, 0);
    txn("R13", 1'b1, 20'h00002, 32'h55667788, 32'h0, 0);

    // R8: split write
    cfg_wr_split = 1'b1;
    txn("R8", 1'b1, 20'hF0F0F, 32'h0BADCAFE, 32'h0, 0);

    // R9: ready stalls on the first phase of read and split write
    txn("R9", 1'b1, 20'h00ABC, 32'h13579BDF, 32'h0, 1);
    cfg_wr_split = 1'b0;
    txn("R9", 1'b0, 20'h00ABD, 32'h0, 32'h2468ACE0, 2);
    txn("R9", 1'b1, 20'h00ABE, 32'hFEDCBA98, 32'h0, 3);

    // R10: ready ignored when not honoured
    cfg_rdy_en = 1'b0; force_low = 1'b1;
    txn("R10", 1'b0, 20'h00777, 32'h0, 32'h0F0F0F0F, 0);
    cfg_rdy_en = 1'b1; cfg_clk_gated = 1'b1;
    // R4: gated clock, ready requested but not honoured
    txn("R10", 1'b0, 20'h00778, 32'h0, 32'h77777777, 0);
    force_low = 1'b0;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (bus_clk) cnt++;
    end
    chk("R4", "idle high clocks", cnt, 6);
    txn("R4", 1'b0, 20'h00101, 32'h0, 32'h89ABCDEF, 0);
    txn("R4", 1'b1, 20'h00102, 32'h01020304, 32'h0, 0);
    cfg_wr_split = 1'b1;
    txn("R4", 1'b1, 20'h00103, 32'h05060708, 32'h0, 0);
    cfg_wr_split = 1'b0;

    // R2: clock disabled
    cfg_clk_en = 1'b0; cfg_clk_gated = 1'b0;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bus_clk) cnt++;
    end
    chk("R2", "high clocks while off", cnt, 0);
    txn("R2", 1'b0, 20'h00200, 32'h0, 32'hA0B0C0D0, 0);
    chk("R2", "clock after read", bus_clk, 1'b0);
    cfg_clk_en = 1'b1;

    // R5: strobes disabled
    cfg_strobe_en = 1'b0;
    txn("R5", 1'b0, 20'h00300, 32'h0, 32'h31415926, 0);
    txn("R5", 1'b1, 20'h00301, 32'h27182818, 32'h0, 0);
    cfg_strobe_en = 1'b1;

    // R11: address widths
    cfg_addr_mode = 2'd0; txn("R11", 1'b1, 20'hFFFFF, 32'h1, 32'h0, 0);
    cfg_addr_mode = 2'd1; txn("R11", 1'b0, 20'hABCDE, 32'h0, 32'h2, 0);
    cfg_addr_mode = 2'd2; txn("R11", 1'b1, 20'hABCDE, 32'h3, 32'h0, 0);
    cfg_addr_mode = 2'd3; txn("R11", 1'b0, 20'hABCDE, 32'h0, 32'h4, 0);

    // R12: data widths both directions
    cfg_data_mode = 2'd0;
    txn("R12", 1'b1, 20'h00400, 32'h89ABCDEF, 32'h0, 0);
    txn("R12", 1'b0, 20'h00401, 32'h0, 32'hFEDCBA98, 0);
    cfg_data_mode = 2'd1;
    txn("R12", 1'b1, 20'h00402, 32'h89ABCDEF, 32'h0, 0);
    txn("R12", 1'b0, 20'h00403, 32'h0, 32'hFEDCBA98, 0);
    cfg_data_mode = 2'd3;
    txn("R12", 1'b0, 20'h00404, 32'h0, 32'hFEDCBA98, 0);
    cfg_data_mode = 2'd2;

    repeat (6) @(negedge clk);
    chk("R13", "ack count", n_acks, n_txn);
    chk("R13", "pending expectations", expq.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule